// File: doc/BRIEF.md
# Audio Frame Byte Demultiplexer

This block takes one multichannel audio frame, delivered a byte per beat, and spreads its bytes over four output streams. Each input byte position (slot) has a routing entry that names a destination stream, a 32-bit channel word inside that stream, and a byte lane inside that word. A 64-bit slot-enable mask selects which slots take part at all. Because the routing is per byte, any mix of 8, 16, 24 and 32-bit samples and any reordering of channels can be set up purely through the table.

Bytes are gathered into a staging store while the frame arrives. When the beat marked last is accepted, every enabled stream emits its own frame word by word on its own valid/ready port, each stream with its own programmable word count. A busy flag shows that a frame is in progress. A soft-reset request discards any partial input frame and any output not yet delivered, then clears its own pending flag.

The sequencer has four states. IDLE (not busy, input open) goes to COLLECT when a byte without the last mark is taken, or directly to EMIT when that byte carries it. COLLECT goes to EMIT when the last-marked beat is taken. EMIT returns to IDLE once every enabled stream has handed over its final word. Any of IDLE, COLLECT and EMIT moves to FLUSH when a soft reset is pending, and FLUSH always returns to IDLE in the next cycle.

Top module: `adx_byte_demux`

## Requirements
- R1: A routing entry is 8 bits: bits 7:6 give the stream (0 to 3), bits 5:2 the word (0 to 15) and bits 1:0 the byte lane (0 to 3); lane 0 sits in bits 7:0 of the 32-bit output word, and stream s drives bits 32*s+31 to 32*s of `out_data`.
- R2: Slot i is forwarded only when bit i of {`slot_en_hi`, `slot_en_lo`} is 1 (`slot_en_lo` covers slots 0 to 31); a masked slot leaves its target untouched.
- R3: Every output byte that no enabled slot of the current frame targets reads zero, whatever earlier frames carried.
- R4: When two enabled slots target the same output byte, the higher-numbered slot's byte is emitted.
- R5: No output word is offered before the last-marked input beat is accepted; all enabled streams raise valid in the cycle right after it, and `in_ready` stays low until emission ends.
- R6: An enabled stream s emits exactly `ch_count_m1[4*s+3:4*s]`+1 words in order 0, 1, 2, ..., with `out_last` set on the final one only.
- R7: A stream whose `stream_en` bit (bit s for stream s) is 0 emits no word; with all bits 0 the frame is dropped and the block returns to idle.
- R8: While a stream's valid is high and its ready is low, its valid, data and last hold unchanged.
- R9: `busy` is 0 after reset and while idle, and 1 from the cycle after the first byte of a frame is accepted until the last word has been delivered.
- R10: A one-cycle `soft_rst_req` raises `soft_rst_busy` in the next cycle, that flag clears by itself two cycles later; the partial frame and all undelivered output are dropped, routing entries are kept.
- R11: Only the first 64 bytes of a frame are routed; later beats are accepted and discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_req | input | 1 | Soft-reset request pulse |
| soft_rst_busy | output | 1 | Soft reset pending, clears itself |
| busy | output | 1 | Frame in progress |
| map_we | input | 1 | Routing entry write strobe |
| map_slot | input | 6 | Slot whose entry is written |
| map_entry | input | 8 | Routing entry {stream, word, lane} |
| slot_en_lo | input | 32 | Enables for slots 0 to 31 |
| slot_en_hi | input | 32 | Enables for slots 32 to 63 |
| stream_en | input | 4 | Per-stream output enable |
| ch_count_m1 | input | 16 | Per-stream word count minus one, 4 bits each |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_byte | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| out_valid | output | 4 | Per-stream word valid |
| out_ready | input | 4 | Per-stream word ready |
| out_last | output | 4 | Per-stream final-word flag |
| out_data | output | 128 | Per-stream 32-bit word |

## Verification
The routing is exercised with an identity table that fills each stream in order, a scrambled table that sends slots to mixed words and lanes under a sparse mask and varying word counts, and a table where two slots collide on one byte; together these separate wrong field decoding, wrong lane order, mask misuse and a wrong collision winner. Short frames after full ones reveal stale bytes, frames longer than 64 bytes reveal slot-counter overrun, and partial or all-off stream enables reveal leaks to disabled ports. Random and held-low ready patterns separate correct per-stream handshake from words lost or repeated, and soft resets during collection and during emission show whether stale state survives a flush.

// File: rtl/adx_pkg.sv
package adx_pkg;

    // Field widths of one routing entry.
    localparam int STREAM_W  = 2;
    localparam int WORD_W    = 4;
    localparam int LANE_W    = 2;

    localparam int NUM_STREAMS = 1 << STREAM_W;
    localparam int NUM_WORDS   = 1 << WORD_W;
    localparam int NUM_LANES   = 1 << LANE_W;
    localparam int WORD_BITS   = 8 * NUM_LANES;

    // Bit order inside the entry is behaviour: {stream, word, lane}.
    typedef struct packed {
        logic [STREAM_W-1:0] stream;
        logic [WORD_W-1:0]   word;
        logic [LANE_W-1:0]   lane;
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_EMIT,
        ST_FLUSH
    } seq_state_t;

endpackage

// File: rtl/adx_slot_map.sv
module adx_slot_map
    import adx_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  route_t            wr_route,
    input  logic [SLOT_W-1:0] rd_slot,
    output route_t            rd_route
);

    route_t table_q [NUM_SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                table_q[i] <= '0;
            end
        end else if (wr_en) begin
            table_q[wr_slot] <= wr_route;
        end
    end

    assign rd_route = table_q[rd_slot];

endmodule

// File: rtl/adx_frame_store.sv
module adx_frame_store
    import adx_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             wr_en,
    input  route_t                           wr_route,
    input  logic [7:0]                       wr_byte,
    input  logic [NUM_STREAMS*WORD_W-1:0]    rd_word,
    output logic [NUM_STREAMS*WORD_BITS-1:0] rd_data
);

    logic [7:0] cell_q [NUM_STREAMS][NUM_WORDS][NUM_LANES];

    // A write in the same cycle as a clear wins for its own byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_STREAMS; s++)
                for (int w = 0; w < NUM_WORDS; w++)
                    for (int l = 0; l < NUM_LANES; l++)
                        cell_q[s][w][l] <= '0;
        end else begin
            if (clr) begin
                for (int s = 0; s < NUM_STREAMS; s++)
                    for (int w = 0; w < NUM_WORDS; w++)
                        for (int l = 0; l < NUM_LANES; l++)
                            cell_q[s][w][l] <= '0;
            end
            if (wr_en) begin
                cell_q[wr_route.stream][wr_route.word][wr_route.lane] <= wr_byte;
            end
        end
    end

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
            assign rd_data[s*WORD_BITS + l*8 +: 8] =
                cell_q[s][rd_word[s*WORD_W +: WORD_W]][l];
        end
    end

endmodule

// File: rtl/adx_seq_ctrl.sv
module adx_seq_ctrl
    import adx_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst_req,
    input  logic                          in_valid,
    input  logic                          in_last,
    input  logic [NUM_STREAMS-1:0]        stream_en,
    input  logic [NUM_STREAMS*WORD_W-1:0] ch_count_m1,
    input  logic [NUM_STREAMS-1:0]        out_ready,
    output logic                          in_ready,
    output logic                          take_byte,
    output logic [SLOT_W-1:0]             slot_idx,
    output logic                          slot_in_range,
    output logic                          store_clr,
    output logic [NUM_STREAMS-1:0]        out_valid,
    output logic [NUM_STREAMS-1:0]        out_last,
    output logic [NUM_STREAMS*WORD_W-1:0] word_sel,
    output logic                          busy,
    output logic                          soft_rst_busy
);

    seq_state_t               state_q, state_d;
    logic                     rst_pend_q;
    logic [SLOT_W:0]          slot_q;
    logic [NUM_STREAMS-1:0]   pend_q;
    logic [WORD_W-1:0]        wc_q [NUM_STREAMS];
    logic [NUM_STREAMS-1:0]   fire;
    logic [NUM_STREAMS-1:0]   at_last;
    logic                     frame_end;
    logic                     emit_done;

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_flags
        assign at_last[s]               = (wc_q[s] == ch_count_m1[s*WORD_W +: WORD_W]);
        assign fire[s]                  = pend_q[s] & out_ready[s];
        assign word_sel[s*WORD_W +: WORD_W] = wc_q[s];
    end

    assign take_byte     = in_valid & in_ready;
    assign frame_end     = take_byte & in_last;
    assign emit_done     = ((pend_q & ~(fire & at_last)) == '0);
    assign slot_in_range = (slot_q < (SLOT_W+1)'(NUM_SLOTS));
    assign slot_idx      = slot_q[SLOT_W-1:0];

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_pend_q)     state_d = ST_FLUSH;
                else if (frame_end) state_d = ST_EMIT;
                else if (take_byte) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (rst_pend_q)     state_d = ST_FLUSH;
                else if (frame_end) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (rst_pend_q)     state_d = ST_FLUSH;
                else if (emit_done) state_d = ST_IDLE;
            end
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State-decoded outputs.
    always_comb begin
        in_ready  = 1'b0;
        busy      = 1'b1;
        store_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready  = ~rst_pend_q;
                busy      = 1'b0;
                store_clr = 1'b1;
            end
            ST_COLLECT: in_ready  = ~rst_pend_q;
            ST_EMIT:    in_ready  = 1'b0;
            ST_FLUSH:   store_clr = 1'b1;
            default:    busy      = 1'b1;
        endcase
    end

    // Soft-reset flag: set by a request, cleared by the flush cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rst_pend_q <= 1'b0;
        else if (state_q == ST_FLUSH) rst_pend_q <= soft_rst_req;
        else if (soft_rst_req)       rst_pend_q <= 1'b1;
    end

    // Slot counter saturates one past the last routable slot.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (frame_end) begin
            slot_q <= '0;
        end else if (take_byte) begin
            if (slot_in_range) slot_q <= slot_q + 1'b1;
        end else if (state_q != ST_COLLECT) begin
            slot_q <= '0;
        end
    end

    // Per-stream emission state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int s = 0; s < NUM_STREAMS; s++) wc_q[s] <= '0;
        end else if (rst_pend_q) begin
            pend_q <= '0;
        end else if (frame_end) begin
            pend_q <= stream_en;
            for (int s = 0; s < NUM_STREAMS; s++) wc_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_STREAMS; s++) begin
                if (fire[s]) begin
                    if (at_last[s]) pend_q[s] <= 1'b0;
                    else            wc_q[s]   <= wc_q[s] + 1'b1;
                end
            end
        end
    end

    assign out_valid     = pend_q;
    assign out_last      = pend_q & at_last;
    assign soft_rst_busy = rst_pend_q;

endmodule

// File: rtl/adx_byte_demux.sv
module adx_byte_demux
    import adx_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    localparam int SLOT_W   = $clog2(NUM_SLOTS),
    localparam int ENTRY_W  = $bits(route_t)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             soft_rst_req,
    output logic                             soft_rst_busy,
    output logic                             busy,
    input  logic                             map_we,
    input  logic [SLOT_W-1:0]                map_slot,
    input  logic [ENTRY_W-1:0]               map_entry,
    input  logic [31:0]                      slot_en_lo,
    input  logic [31:0]                      slot_en_hi,
    input  logic [NUM_STREAMS-1:0]           stream_en,
    input  logic [NUM_STREAMS*WORD_W-1:0]    ch_count_m1,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [7:0]                       in_byte,
    input  logic                             in_last,
    output logic [NUM_STREAMS-1:0]           out_valid,
    input  logic [NUM_STREAMS-1:0]           out_ready,
    output logic [NUM_STREAMS-1:0]           out_last,
    output logic [NUM_STREAMS*WORD_BITS-1:0] out_data
);

    logic [63:0]                     slot_mask;
    logic                            take_byte;
    logic [SLOT_W-1:0]               slot_idx;
    logic                            slot_in_range;
    logic                            store_clr;
    logic                            store_we;
    route_t                          cur_route;
    logic [NUM_STREAMS*WORD_W-1:0]   word_sel;

    assign slot_mask = {slot_en_hi, slot_en_lo};
    assign store_we  = take_byte & slot_in_range & slot_mask[slot_idx];

    adx_seq_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst_req  (soft_rst_req),
        .in_valid      (in_valid),
        .in_last       (in_last),
        .stream_en     (stream_en),
        .ch_count_m1   (ch_count_m1),
        .out_ready     (out_ready),
        .in_ready      (in_ready),
        .take_byte     (take_byte),
        .slot_idx      (slot_idx),
        .slot_in_range (slot_in_range),
        .store_clr     (store_clr),
        .out_valid     (out_valid),
        .out_last      (out_last),
        .word_sel      (word_sel),
        .busy          (busy),
        .soft_rst_busy (soft_rst_busy)
    );

    adx_slot_map #(.NUM_SLOTS(NUM_SLOTS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (map_we),
        .wr_slot  (map_slot),
        .wr_route (route_t'(map_entry)),
        .rd_slot  (slot_idx),
        .rd_route (cur_route)
    );

    adx_frame_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (store_clr),
        .wr_en    (store_we),
        .wr_route (cur_route),
        .wr_byte  (in_byte),
        .rd_word  (word_sel),
        .rd_data  (out_data)
    );

endmodule

// File: rtl/adx_demux_checks.sv
module adx_demux_checks
    import adx_pkg::*;
(
    input logic                             clk,
    input logic                             rst_n,
    input logic                             soft_rst_req,
    input logic                             soft_rst_busy,
    input logic                             busy,
    input logic                             in_ready,
    input logic [NUM_STREAMS-1:0]           out_valid,
    input logic [NUM_STREAMS-1:0]           out_ready,
    input logic [NUM_STREAMS-1:0]           out_last,
    input logic [NUM_STREAMS*WORD_BITS-1:0] out_data
);

    // R5: input closed while any word is on offer.
    a_r5_no_input_while_emit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid != '0) |-> !in_ready);

    // R9: idle block offers nothing.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (out_valid == '0));

    // R10: output dropped once the flush is under way.
    a_r10_flush_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_busy && $past(soft_rst_busy)) |-> (out_valid == '0));

    // R10: flag clears itself two cycles after a lone request.
    a_r10_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(soft_rst_busy, 2) && $past(soft_rst_busy) &&
         !$past(soft_rst_req) && !$past(soft_rst_req, 2)) |-> !soft_rst_busy);

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_port
        // R8: offer holds under back-pressure.
        a_r8_hold_offer: assert property (@(posedge clk) disable iff (!rst_n || soft_rst_busy)
            (out_valid[s] && !out_ready[s]) |=>
                (out_valid[s] && $stable(out_data[s*WORD_BITS +: WORD_BITS]) && $stable(out_last[s])));

        // R6: last only marks an offered word.
        a_r6_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_last[s] |-> out_valid[s]);
    end

endmodule

bind adx_byte_demux adx_demux_checks u_chk (.*);

// File: tb/adx_byte_demux_test.sv
module adx_byte_demux_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         soft_rst_req = 1'b0;
    logic         soft_rst_busy;
    logic         busy;
    logic         map_we = 1'b0;
    logic [5:0]   map_slot = '0;
    logic [7:0]   map_entry = '0;
    logic [63:0]  mask = '1;
    logic [3:0]   en = 4'hF;
    logic [15:0]  chm1 = 16'h3333;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_byte = '0;
    logic         in_last = 1'b0;
    logic [3:0]   out_valid;
    logic [3:0]   out_ready = 4'h0;
    logic [3:0]   out_last;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit mon_on = 0;
    int rdy_mode = 0;
    string tag = "R1";

    int bm_s [64];
    int bm_w [64];
    int bm_l [64];
    logic [7:0] fdata [80];
    logic [32:0] expq [4][$];

    always #5 clk = ~clk;

    adx_byte_demux uut (
        .clk(clk), .rst_n(rst_n), .soft_rst_req(soft_rst_req),
        .soft_rst_busy(soft_rst_busy), .busy(busy),
        .map_we(map_we), .map_slot(map_slot), .map_entry(map_entry),
        .slot_en_lo(mask[31:0]), .slot_en_hi(mask[63:32]),
        .stream_en(en), .ch_count_m1(chm1),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last), .out_data(out_data)
    );

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model compared on every clock (negedge, ahead of the coming edge).
    always @(negedge clk) begin
        cycles++;
        if (mon_on) begin
            for (int s = 0; s < 4; s++) begin
                out_ready[s] = (rdy_mode == 0) ? 1'b1 :
                               (rdy_mode == 1) ? (($urandom % 3) != 0) : 1'b0;
                if (out_valid[s] && out_ready[s]) begin
                    if (expq[s].size() == 0) begin
                        chk("R7", $sformatf("unexpected word s%0d", s), 128'(out_valid[s]), 128'd0);
                    end else begin
                        logic [32:0] e;
                        e = expq[s].pop_front();
                        chk(tag, $sformatf("data s%0d", s), 128'(out_data[s*32 +: 32]), 128'(e[31:0]));
                        chk("R6", $sformatf("last s%0d", s), 128'(out_last[s]), 128'(e[32]));
                    end
                end
            end
        end
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog R9 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic set_map(input int slot, input int s, input int w, input int l);
        bm_s[slot] = s; bm_w[slot] = w; bm_l[slot] = l;
        @(negedge clk);
        map_we = 1'b1; map_slot = 6'(slot);
        map_entry = {2'(s), 4'(w), 2'(l)};
        @(negedge clk);
        map_we = 1'b0;
    endtask

    task automatic push_expected(input int n);
        logic [7:0] eb [4][16][4];
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 16; w++)
                for (int l = 0; l < 4; l++) eb[s][w][l] = 8'h00;
        for (int i = 0; i < n && i < 64; i++)
            if (mask[i]) eb[bm_s[i]][bm_w[i]][bm_l[i]] = fdata[i];
        for (int s = 0; s < 4; s++) begin
            if (en[s]) begin
                int last_w;
                last_w = int'(chm1[s*4 +: 4]);
                for (int w = 0; w <= last_w; w++)
                    expq[s].push_back({(w == last_w), eb[s][w][3], eb[s][w][2], eb[s][w][1], eb[s][w][0]});
            end
        end
    endtask

    task automatic send_frame(input int n, input bit do_last);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = fdata[i]; in_last = do_last && (i == n-1);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        if (do_last) push_expected(n);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        if (do_last) begin
            chk("R5", "valid right after last", 128'(out_valid), 128'(en));
            chk("R5", "input closed", 128'(in_ready), 128'd0);
            chk("R9", "busy during frame", 128'(busy), 128'd1);
        end else begin
            chk("R5", "no output before last", 128'(out_valid), 128'd0);
            chk("R9", "busy while collecting", 128'(busy), 128'd1);
        end
    endtask

    task automatic drain();
        int t = 0;
        while ((expq[0].size() + expq[1].size() + expq[2].size() + expq[3].size() != 0 || busy) && t < 3000) begin
            @(negedge clk); t++;
        end
        @(negedge clk);
        for (int s = 0; s < 4; s++)
            chk("R6", $sformatf("word count s%0d", s), 128'(expq[s].size()), 128'd0);
        chk("R9", "idle after frame", 128'(busy), 128'd0);
    endtask

    task automatic pulse_soft_reset();
        @(negedge clk); soft_rst_req = 1'b1;
        @(negedge clk); soft_rst_req = 1'b0;
        chk("R10", "flag raised", 128'(soft_rst_busy), 128'd1);
        @(negedge clk);
        chk("R10", "flag held", 128'(soft_rst_busy), 128'd1);
        chk("R10", "output dropped", 128'(out_valid), 128'd0);
        @(negedge clk);
        chk("R10", "flag cleared", 128'(soft_rst_busy), 128'd0);
        chk("R10", "input reopened", 128'(in_ready), 128'd1);
    endtask

    task automatic identity_map();
        for (int i = 0; i < 64; i++) set_map(i, i / 16, (i % 16) / 4, i % 4);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "reset busy", 128'(busy), 128'd0);
        chk("R5", "reset in_ready", 128'(in_ready), 128'd1);
        chk("R6", "reset out_valid", 128'(out_valid), 128'd0);
        chk("R10", "reset soft flag", 128'(soft_rst_busy), 128'd0);
        mon_on = 1;

        // R1: identity routing, full frame.
        identity_map();
        for (int i = 0; i < 80; i++) fdata[i] = 8'(i + 1);
        tag = "R1"; rdy_mode = 0;
        send_frame(64, 1); drain();

        // R2: sparse mask, scrambled routing, mixed counts, random ready.
        for (int i = 0; i < 64; i++) set_map(i, (i * 3) % 4, (i * 5) % 16, (i * 7) % 4);
        mask = 64'h0FF0_3C3C_A5A5_F00F; chm1 = 16'h307F;
        for (int i = 0; i < 80; i++) fdata[i] = 8'(i * 37 + 11);
        tag = "R2"; rdy_mode = 1;
        send_frame(64, 1); drain();

        // R3: short frame after a full one leaves zeros elsewhere.
        identity_map(); mask = '1; chm1 = 16'hFFFF;
        for (int i = 0; i < 80; i++) fdata[i] = 8'(200 - i);
        tag = "R3"; rdy_mode = 0;
        send_frame(64, 1); drain();
        send_frame(10, 1); drain();

        // R4: slots 5 and 9 collide, slot 33 masked out.
        set_map(5, 2, 0, 1); set_map(9, 2, 0, 1);
        mask = ~(64'd1 << 33); chm1 = 16'h3333;
        tag = "R4"; rdy_mode = 1;
        send_frame(64, 1); drain();
        mask = '1;

        // R7: partial and empty stream enables.
        identity_map();
        en = 4'b0101; tag = "R7"; rdy_mode = 0;
        send_frame(64, 1); drain();
        en = 4'b0000;
        send_frame(64, 1); drain();
        en = 4'hF;

        // R11: over-long frame.
        for (int i = 0; i < 80; i++) fdata[i] = 8'(i + 100);
        tag = "R11"; rdy_mode = 1;
        send_frame(70, 1); drain();

        // R8: hold under back-pressure.
        tag = "R8"; rdy_mode = 2;
        send_frame(64, 1);
        repeat (5) @(negedge clk);
        chk("R8", "valid held", 128'(out_valid), 128'hF);
        for (int s = 0; s < 4; s++)
            chk("R8", $sformatf("data held s%0d", s), 128'(out_data[s*32 +: 32]), 128'(expq[s][0][31:0]));
        rdy_mode = 0; drain();

        // R10: soft reset in mid-collection, then a clean frame.
        tag = "R10";
        for (int i = 0; i < 80; i++) fdata[i] = 8'hEE;
        send_frame(20, 0);
        pulse_soft_reset();
        chk("R10", "busy cleared", 128'(busy), 128'd0);
        for (int i = 0; i < 80; i++) fdata[i] = 8'(i + 1);
        send_frame(8, 1); drain();

        // R10: soft reset while words are held back.
        rdy_mode = 2;
        send_frame(64, 1);
        pulse_soft_reset();
        for (int s = 0; s < 4; s++) expq[s].delete();
        rdy_mode = 0;
        repeat (3) @(negedge clk);
        chk("R10", "no output after flush", 128'(out_valid), 128'd0);
        chk("R10", "idle after flush", 128'(busy), 128'd0);

        // R10: routing entries survive the flush.
        tag = "R10";
        send_frame(64, 1); drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule